// File: doc/BRIEF.md
# Channel-Status and User-Bit Block Capture

This block sits behind a two-channel digital audio receiver that already recovers each subframe. Every decoded subframe arrives as one stream beat. The beat carries the channel index, the subframe's channel-status bit, its user bit and a flag that marks the first frame of a 192-frame block. For each channel the block gathers a 192-bit channel-status block and a 192-bit user block. Each finished block is published as six read-only 32-bit words on a small read bus.

Bits are filled least significant first, one per frame, starting at the frame that carries the block-start flag. New bits go into a hidden shadow copy. The readable copy is replaced in a single clock only when the block is complete, so a read never returns a mix of two blocks. The block pulses an end-of-block event whenever a block is published. It pulses a per-channel change event when the newly published status block differs from the one it replaces, and it pulses a block-start event when a start flag is accepted.

The subframe input is valid/ready. `sf_ready` is held high in every cycle, so the block never applies back-pressure. A beat is taken in each cycle in which `sf_valid` is high, and the upstream decoder never has to stall.

Top module: `cub_capture`

## Requirements
- R1: After reset every readable word reads 0 and `irq_evt` is all zero.
- R2: A beat with `sf_chan`=0 and `sf_bstart`=1 starts a block at frame 0 and pulses `irq_evt[11]` in the cycle after it is accepted. A start flag on a channel-1 beat is treated as an ordinary beat.
- R3: The C and U bits of frame f, for f from 0 to 191, go to bit f of that channel's block, and word w holds block bits 32w+31 down to 32w. Read byte 0 of a word is therefore bits 7:0 of the word and holds the lowest-numbered frames.
- R4: Channel-status word w of channel c is read at byte address 0x30 + 0x30·c + 4w. User word w of channel c is read at 0x48 + 0x30·c + 4w, with w from 0 to 5.
- R5: The readable words of both channels change only in the clock that accepts the channel-1 beat of frame 191. `irq_evt[3]` pulses for one cycle in the following cycle.
- R6: `irq_evt[8+c]` pulses together with `irq_evt[3]` only when the new channel-status block of channel c differs from the previously readable one. It stays low when the two blocks are equal.
- R7: A channel-0 start flag that arrives before a block completes drops the partial block. The readable words stay as they were, and filling restarts at frame 0.
- R8: Beats that arrive before the first start flag, or after a block completes and before the next start flag, change no readable word and raise no event.
- R9: A read returns data on `rd_data` one cycle after `rd_en`. A read of a byte address outside the map of R4, or of an unaligned address, returns 0. A read in the clock that publishes a block returns the word from before publication.
- R10: `sf_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | Decoded subframe beat present |
| sf_ready | output | 1 | Always 1; the block never stalls the stream |
| sf_chan | input | CH_W | Channel index of the subframe |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| sf_ubit | input | 1 | User bit of the subframe |
| sf_bstart | input | 1 | Subframe is in the first frame of a block |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | WORD_W | Read data, one cycle after rd_en |
| irq_evt | output | EVT_W | Event pulses: bit 3 block end, bit 8+c status change of channel c, bit 11 block start |

## Verification
Two functions can fall in the same clock. A read strobe can coincide with the channel-1 beat that publishes a block, and a status-change pulse always shares its cycle with the end-of-block pulse. The bench places a read of channel-0 status word 0 on the very beat that completes a block. It expects the old word in that read and the new word in the next read. The behavioural model also predicts the full event vector on every clock, so a change pulse that is missing, stray or displaced by a cycle is reported against the end-of-block pulse.

// File: rtl/cub_pkg.sv
package cub_pkg;
  localparam int CS_BASE       = 'h30;
  localparam int UD_BASE       = 'h48;
  localparam int CH_STRIDE     = 'h30;
  localparam int EVT_W         = 16;
  localparam int EVT_BLK_END   = 3;
  localparam int EVT_CSC0      = 8;
  localparam int EVT_BLK_START = 11;
endpackage

// File: rtl/cub_frame_ctl.sv
module cub_frame_ctl #(
  parameter int BLK_BITS = 192,
  parameter int NCH      = 2,
  parameter int CH_W     = 1,
  parameter int IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [CH_W-1:0]  ch,
  input  logic             bstart,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             commit,
  output logic             start
);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(BLK_BITS - 1);
  localparam logic [CH_W-1:0]  LAST_CH = CH_W'(NCH - 1);

  logic             armed_q;
  logic [IDX_W-1:0] fidx_q;

  always_comb begin
    start  = acc && (ch == '0) && bstart;
    wr_en  = acc && (armed_q || start);
    wr_idx = start ? '0 : fidx_q;
    commit = wr_en && (ch == LAST_CH) && (wr_idx == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fidx_q  <= '0;
    end else if (start) begin
      armed_q <= 1'b1;
      fidx_q  <= '0;
    end else if (commit) begin
      armed_q <= 1'b0;
      fidx_q  <= '0;
    end else if (wr_en && (ch == LAST_CH)) begin
      fidx_q  <= fidx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/cub_chan_store.sv
module cub_chan_store #(
  parameter int BLK_BITS = 192,
  parameter int CH_W     = 1,
  parameter int IDX_W    = 8,
  parameter int CH_ID    = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                cbit,
  input  logic                ubit,
  input  logic                commit,
  output logic [BLK_BITS-1:0] cs_vis,
  output logic [BLK_BITS-1:0] ud_vis,
  output logic                csc
);
  logic [BLK_BITS-1:0] cs_sh, ud_sh, cs_nx, ud_nx;

  always_comb begin
    cs_nx = cs_sh;
    ud_nx = ud_sh;
    if (wr_en && (wr_ch == CH_W'(CH_ID))) begin
      cs_nx[wr_idx] = cbit;
      ud_nx[wr_idx] = ubit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sh  <= '0;
      ud_sh  <= '0;
      cs_vis <= '0;
      ud_vis <= '0;
      csc    <= 1'b0;
    end else begin
      cs_sh <= cs_nx;
      ud_sh <= ud_nx;
      csc   <= commit && (cs_nx != cs_vis);
      if (commit) begin
        cs_vis <= cs_nx;
        ud_vis <= ud_nx;
      end
    end
  end
endmodule

// File: rtl/cub_reg_read.sv
module cub_reg_read
  import cub_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int BLK_BITS = 192,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [NCH-1:0][BLK_BITS-1:0]  cs_vis,
  input  logic [NCH-1:0][BLK_BITS-1:0]  ud_vis,
  output logic [WORD_W-1:0]             rd_data
);
  localparam int WORDS      = BLK_BITS / WORD_W;
  localparam int WORD_BYTES = WORD_W / 8;

  logic [WORD_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (rd_addr == ADDR_W'(CS_BASE + c * CH_STRIDE + w * WORD_BYTES))
          sel = cs_vis[c][w*WORD_W +: WORD_W];
        if (rd_addr == ADDR_W'(UD_BASE + c * CH_STRIDE + w * WORD_BYTES))
          sel = ud_vis[c][w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/cub_capture.sv
module cub_capture
  import cub_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int BLK_BITS = 192,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int IDX_W    = $clog2(BLK_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_valid,
  output logic              sf_ready,
  input  logic [CH_W-1:0]   sf_chan,
  input  logic              sf_cbit,
  input  logic              sf_ubit,
  input  logic              sf_bstart,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [EVT_W-1:0]  irq_evt
);
  logic                         acc, wr_en, commit, start;
  logic [IDX_W-1:0]             wr_idx;
  logic [NCH-1:0][BLK_BITS-1:0] cs_vis, ud_vis;
  logic [NCH-1:0]               csc;
  logic                         end_q, start_q;

  assign sf_ready = 1'b1;
  assign acc      = sf_valid;

  cub_frame_ctl #(.BLK_BITS(BLK_BITS), .NCH(NCH), .CH_W(CH_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .acc(acc), .ch(sf_chan), .bstart(sf_bstart),
    .wr_en(wr_en), .wr_idx(wr_idx), .commit(commit), .start(start)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cub_chan_store #(.BLK_BITS(BLK_BITS), .CH_W(CH_W), .IDX_W(IDX_W), .CH_ID(c)) u_st (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(sf_chan), .wr_idx(wr_idx),
      .cbit(sf_cbit), .ubit(sf_ubit), .commit(commit),
      .cs_vis(cs_vis[c]), .ud_vis(ud_vis[c]), .csc(csc[c])
    );
  end

  cub_reg_read #(.NCH(NCH), .BLK_BITS(BLK_BITS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .cs_vis(cs_vis), .ud_vis(ud_vis), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      end_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      end_q   <= commit;
      start_q <= start;
    end
  end

  always_comb begin
    irq_evt = '0;
    irq_evt[EVT_BLK_END]   = end_q;
    irq_evt[EVT_BLK_START] = start_q;
    irq_evt[EVT_CSC0 +: NCH] = csc;
  end
endmodule

// File: rtl/cub_capture_chk.sv
module cub_capture_chk #(
  parameter int NCH      = 2,
  parameter int BLK_BITS = 192,
  parameter int CH_W     = 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sf_valid,
  input logic [CH_W-1:0]              sf_chan,
  input logic                         sf_bstart,
  input logic                         blk_end,
  input logic                         blk_start,
  input logic [NCH-1:0]               csc,
  input logic [NCH-1:0][BLK_BITS-1:0] cs_vis,
  input logic [NCH-1:0][BLK_BITS-1:0] ud_vis
);
  // R5
  blk_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> !blk_end);

  // R5
  blk_end_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> $past(sf_valid && (sf_chan == CH_W'(NCH - 1))));

  // R5
  vis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_end |-> ($stable(cs_vis) && $stable(ud_vis)));

  // R2
  blk_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> $past(sf_valid && (sf_chan == '0) && sf_bstart));

  // R6
  csc_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csc != '0) |-> blk_end);
endmodule

bind cub_capture cub_capture_chk #(.NCH(NCH), .BLK_BITS(BLK_BITS), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan(sf_chan),
  .sf_bstart(sf_bstart), .blk_end(irq_evt[3]), .blk_start(irq_evt[11]),
  .csc(irq_evt[8 +: NCH]), .cs_vis(cs_vis), .ud_vis(ud_vis)
);

// File: tb/sim_cub_capture.sv
module sim_cub_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sf_valid = 1'b0, sf_cbit = 1'b0, sf_ubit = 1'b0, sf_bstart = 1'b0;
  logic [0:0]  sf_chan = 1'b0;
  logic        sf_ready;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] irq_evt;

  int checks = 0, errors = 0, cyc = 0;

  cub_capture u0 (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_ready(sf_ready),
    .sf_chan(sf_chan), .sf_cbit(sf_cbit), .sf_ubit(sf_ubit), .sf_bstart(sf_bstart),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_evt(irq_evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [191:0] m_sh_c [2], m_sh_u [2], m_vis_c [2], m_vis_u [2];
  int          m_fidx;
  bit          m_armed;
  logic [15:0] exp_evt;
  logic [31:0] exp_rd;
  bit          rd_chk;

  function automatic logic [31:0] m_read(input int a);
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 6; w++) begin
        if (a == 48 + c*48 + 4*w) return m_vis_c[c][w*32 +: 32];
        if (a == 72 + c*48 + 4*w) return m_vis_u[c][w*32 +: 32];
      end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_sh_c[c] = '0; m_sh_u[c] = '0; m_vis_c[c] = '0; m_vis_u[c] = '0;
      end
      m_fidx = 0; m_armed = 0; exp_evt = '0; rd_chk = 0; exp_rd = '0;
    end else begin
      bit fin;
      rd_chk = rd_en;
      if (rd_en) exp_rd = m_read(int'(rd_addr));
      exp_evt = '0;
      fin = 0;
      if (sf_valid) begin
        if (sf_chan == 0 && sf_bstart) begin
          m_armed = 1; m_fidx = 0; exp_evt[11] = 1'b1;
        end
        if (m_armed) begin
          m_sh_c[sf_chan][m_fidx] = sf_cbit;
          m_sh_u[sf_chan][m_fidx] = sf_ubit;
          if (sf_chan == 1) begin
            if (m_fidx == 191) fin = 1;
            else m_fidx++;
          end
        end
        if (fin) begin
          for (int c = 0; c < 2; c++) begin
            if (m_sh_c[c] != m_vis_c[c]) exp_evt[8+c] = 1'b1;
            m_vis_c[c] = m_sh_c[c];
            m_vis_u[c] = m_sh_u[c];
          end
          exp_evt[3] = 1'b1;
          m_armed = 0; m_fidx = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 R5 R6 R7 R8 irq_evt", {16'h0, irq_evt}, {16'h0, exp_evt});
      if (rd_chk) check("R3 R4 R9 rd_data", rd_data, exp_rd);
    end
  end

  // ---------------- stimulus ----------------
  bit         nx_rd = 0;
  logic [7:0] nx_addr = '0;

  function automatic bit pat(input int p, input int ch, input bit usr, input int f);
    case (p)
      1: return usr ? bit'((f % 2) ^ ch) : (ch == 0 ? (f % 3 == 0) : (f % 5 == 0));
      2: return usr ? (f % 4 == 1) : (ch == 0 ? (f % 3 == 0) : (f % 7 == 0));
      3: return usr ? (ch == 1 && f == 40) : (ch == 0 && f == 8);
      default: return 1'b0;
    endcase
  endfunction

  task automatic sf(input int ch, input bit c, input bit u, input bit bs);
    @(negedge clk);
    sf_valid = 1'b1; sf_chan = 1'(ch); sf_cbit = c; sf_ubit = u; sf_bstart = bs;
    rd_en = nx_rd; rd_addr = nx_addr; nx_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sf_valid = 1'b0; sf_bstart = 1'b0; rd_en = 1'b0;
    end
  endtask

  task automatic frames(input int p, input bit marker, input int from, input int upto);
    for (int f = from; f < upto; f++) begin
      sf(0, pat(p, 0, 0, f), pat(p, 0, 1, f), marker && f == 0);
      if (f == 191 && nx_addr != 8'h00) nx_rd = 1;
      sf(1, pat(p, 1, 0, f), pat(p, 1, 1, f), 1'b0);
    end
  endtask

  task automatic rd_direct(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    sf_valid = 1'b0; sf_bstart = 1'b0; rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rd_data, exp);
  endtask

  task automatic rd_all();
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 6; w++) begin
        rd_direct("R1 R4 cs word", 8'(48 + c*48 + 4*w), m_read(48 + c*48 + 4*w));
        rd_direct("R1 R4 ud word", 8'(72 + c*48 + 4*w), m_read(72 + c*48 + 4*w));
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq_evt after reset", {16'h0, irq_evt}, 32'h0);
    rst_n = 1'b1;
    idle(1);
    rd_all();                                      // R1 all words zero
    check("R10 sf_ready", {31'h0, sf_ready}, 32'h1);

    frames(1, 1'b0, 0, 20);                        // R8 no marker yet
    sf(1, 1'b1, 1'b1, 1'b1);                       // R2 marker on channel 1 ignored
    sf(1, 1'b1, 1'b0, 1'b1);
    idle(2);
    rd_direct("R8 before marker cs0w0", 8'h30, 32'h0);

    frames(1, 1'b1, 0, 100);                       // R5 partial block
    rd_direct("R5 mid-block cs0w0 unchanged", 8'h30, 32'h0);
    frames(1, 1'b0, 100, 192);
    idle(2);
    rd_direct("R3 cs0w0 pattern", 8'h30, 32'h4924_9249);
    rd_all();

    frames(1, 1'b1, 0, 192);                       // R6 equal block, no change event
    frames(2, 1'b1, 0, 192);                       // R6 channel 1 changes only
    idle(2);
    check("R10 sf_ready", {31'h0, sf_ready}, 32'h1);

    frames(1, 1'b1, 0, 100);                       // R7 early restart
    nx_addr = 8'h30;                               // R9 read coincides with publish
    frames(3, 1'b1, 0, 192);
    nx_addr = 8'h00;
    idle(2);
    rd_direct("R7 R3 cs0w0 after restart", 8'h30, 32'h0000_0100);
    rd_direct("R4 ud1w1", 8'h7C, 32'h0000_0100);

    frames(1, 1'b0, 0, 50);                        // R8 after block end
    idle(2);
    rd_direct("R8 after end cs0w0", 8'h30, 32'h0000_0100);

    rd_direct("R9 addr 0x00", 8'h00, 32'h0);
    rd_direct("R9 addr 0x32", 8'h32, 32'h0);
    rd_direct("R9 addr 0x4A", 8'h4A, 32'h0);
    rd_direct("R9 addr 0x90", 8'h90, 32'h0);
    rd_direct("R9 addr 0x2C", 8'h2C, 32'h0);
    rd_all();
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule